// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes from a host into asynchronous serial characters. The host writes a byte into a holding register. The byte moves into an output shift register only when the shifter is idle or its current character has fully gone out. Each character is framed as follows: a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. Each bit lasts 1, 16 or 64 clock periods, chosen by the divide setting.

A holding-empty flag tells the host when it may write again. A clear-to-send input that is high (deasserted) masks this flag. A break request replaces the character stream with a steady low level. Internal state advances on the rising clock edge. The serial output register is updated on the falling edge, so the line changes half a period after each state update. The asynchronous active-low reset is released to the logic through a two-stage synchroniser.

Top module: `async_tx`

## Requirements
- R1: During reset and after it, `txd` is high and `hre` is high while `cts_n` is low.
- R2: A character is sent in this order: one low start bit; then the data bits, least significant first (8 bits when `word8`=1, bits 6..0 when `word8`=0); then the parity bit if enabled; then high stop bits (one when `two_stop`=0, two when `two_stop`=1).
- R3: `par_sel` selects parity: 2'b01 even (the data ones plus the parity bit give an even count), 2'b10 odd (the count is odd), 2'b00 and 2'b11 no parity bit.
- R4: Every bit is held for exactly N clock periods: N=1 for `div_sel`=2'b00, N=16 for 2'b01, N=64 for 2'b10 and 2'b11.
- R5: The holding register moves to the shifter only at a bit boundary, and only when the shifter is idle or its last stop bit is ending. A byte already waiting starts with no idle gap after the previous character. A write during a character does not alter that character.
- R6: `hre` is low in the cycle after a write. It returns high once the byte has moved into the shifter.
- R7: While `cts_n` is high, `hre` is low. Characters are still sent.
- R8: At a bit boundary with `brk` high, the line goes low and stays low for as long as `brk` stays high. Any character in progress is abandoned. A byte in the holding register is kept and is not taken.
- R9: When the break ends, the line goes high for at least one full bit time before the next start bit.
- R10: When nothing is being sent, the line is high. A byte written while the line is idle begins its start bit within N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state on rising edge, line on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| word8 | input | 1 | 1: eight data bits, 0: seven |
| par_sel | input | 2 | Parity select (see R3) |
| two_stop | input | 1 | 1: two stop bits, 0: one |
| div_sel | input | 2 | Clock periods per bit (see R4) |
| brk | input | 1 | Break request |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial line |
| hre | output | 1 | Holding register empty |

## Verification
A write is captured at the next rising edge, so `hre` falls in the following cycle. The start bit then appears between one and N cycles later, depending on where the free-running bit divider stands. After that, each frame bit takes exactly N cycles. The bench therefore samples one nanosecond before each rising edge, after the falling-edge line update has settled. It waits for the first low sample and then compares every single cycle of the frame against a bit pattern it builds arithmetically, so any error in bit length or order shows up. A break takes effect only at the next bit boundary, so the bench waits one full bit time plus margin before it checks for a solid low line. It then counts the high cycles between release and the next start bit.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef enum logic [1:0] {
    PAR_OFF   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ODD   = 2'b10,
    PAR_OFF_B = 2'b11
  } par_e;

  typedef enum logic [1:0] {
    DIV_ONE  = 2'b00,
    DIV_MID  = 2'b01,
    DIV_HI   = 2'b10,
    DIV_HI_B = 2'b11
  } div_e;

  typedef struct packed {
    logic word8;
    par_e par;
    logic two_stop;
  } fmt_t;

endpackage

// File: rtl/async_tx_baud.sv
module async_tx_baud
  import async_tx_pkg::*;
#(
  parameter int MID_N = 16,
  parameter int HI_N  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  div_e div,
  output logic tick
);
  localparam int CW = $clog2(HI_N);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    unique case (div)
      DIV_ONE: lim = '0;
      DIV_MID: lim = CW'(MID_N - 1);
      default: lim = CW'(HI_N - 1);
    endcase
  end

  assign tick = (cnt_q >= lim);

  always_comb begin
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              full_q, full_d;

  always_comb begin
    data_d = data_q;
    full_d = full_q;
    if (take)  full_d = 1'b0;
    if (wr_en) begin
      data_d = wr_data;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
      if (wr_en) data_q <= data_d;
    end
  end

  assign hold_data = data_q;
  assign hold_full = full_q;
endmodule

// File: rtl/async_tx_framer.sv
module async_tx_framer
  import async_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  localparam int FRAME_W = DATA_W + 4,
  localparam int LW      = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  fmt_t               fmt,
  output logic [FRAME_W-1:0] frame,
  output logic [LW-1:0]      len
);
  logic [DATA_W-1:0] dmask, dsel;
  logic              par_en, ones, pbit;

  always_comb begin
    dmask  = fmt.word8 ? '1 : {1'b0, {(DATA_W-1){1'b1}}};
    dsel   = data & dmask;
    ones   = ^dsel;
    par_en = (fmt.par == PAR_EVEN) || (fmt.par == PAR_ODD);
    pbit   = (fmt.par == PAR_ODD) ? ~ones : ones;

    frame           = '1;
    frame[0]        = 1'b0;
    frame[DATA_W:1] = dsel | ~dmask;
    if (par_en) begin
      if (fmt.word8) frame[DATA_W+1] = pbit;
      else           frame[DATA_W]   = pbit;
    end

    len = LW'(DATA_W + 2) - LW'(!fmt.word8) + LW'(par_en) + LW'(fmt.two_stop);
  end
endmodule

// File: rtl/async_tx_shifter.sv
module async_tx_shifter #(
  parameter int FRAME_W = 12,
  localparam int LW = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               brk,
  input  logic               hold_full,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LW-1:0]      len,
  output logic               take,
  output logic               line,
  output logic               busy,
  output logic               brk_state
);
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [LW-1:0]      rem_q, rem_d;
  logic               brk_q, brk_d;

  always_comb begin
    sh_d  = sh_q;
    rem_d = rem_q;
    brk_d = brk_q;
    take  = 1'b0;
    if (tick) begin
      if (brk) begin
        brk_d = 1'b1;
        rem_d = '0;
        sh_d  = '1;
      end else if (brk_q) begin
        brk_d = 1'b0;
        sh_d  = '1;
        rem_d = LW'(1);
      end else if (rem_q > LW'(1)) begin
        sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
        rem_d = rem_q - 1'b1;
      end else if (hold_full) begin
        take  = 1'b1;
        sh_d  = frame;
        rem_d = len;
      end else begin
        sh_d  = '1;
        rem_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      rem_q <= '0;
      brk_q <= 1'b0;
    end else if (tick) begin
      sh_q  <= sh_d;
      rem_q <= rem_d;
      brk_q <= brk_d;
    end
  end

  assign busy      = (rem_q != '0);
  assign brk_state = brk_q;
  assign line      = brk_q ? 1'b0 : (busy ? sh_q[0] : 1'b1);
endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MID_N  = 16,
  parameter int HI_N   = 64,
  localparam int FRAME_W = DATA_W + 4,
  localparam int LW      = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              word8,
  input  logic [1:0]        par_sel,
  input  logic              two_stop,
  input  logic [1:0]        div_sel,
  input  logic              brk,
  input  logic              cts_n,
  output logic              txd,
  output logic              hre
);
  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic               tick, take, hold_full, line, busy, brk_state;
  logic [DATA_W-1:0]  hold_data;
  logic [FRAME_W-1:0] frame;
  logic [LW-1:0]      len;
  fmt_t               fmt;
  logic               txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign fmt = '{word8: word8, par: par_e'(par_sel), two_stop: two_stop};

  async_tx_baud #(.MID_N(MID_N), .HI_N(HI_N)) i_baud (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .div  (div_e'(div_sel)),
    .tick (tick)
  );

  async_tx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .take     (take),
    .hold_data(hold_data),
    .hold_full(hold_full)
  );

  async_tx_framer #(.DATA_W(DATA_W)) i_framer (
    .data (hold_data),
    .fmt  (fmt),
    .frame(frame),
    .len  (len)
  );

  async_tx_shifter #(.FRAME_W(FRAME_W)) i_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick),
    .brk      (brk),
    .hold_full(hold_full),
    .frame    (frame),
    .len      (len),
    .take     (take),
    .line     (line),
    .busy     (busy),
    .brk_state(brk_state)
  );

  always_ff @(negedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) txd_q <= 1'b1;
    else             txd_q <= line;
  end

  assign txd = txd_q;
  assign hre = ~hold_full & ~cts_n;
endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic cts_n,
  input logic hre,
  input logic txd,
  input logic tick,
  input logic hold_full,
  input logic brk_state,
  input logic busy
);
  // R7: a deasserted clear-to-send masks the empty flag
  p_hre_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cts_n |-> !hre);

  // R6: the flag is low right after a write
  p_hre_low_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> !hre);

  // R8: the line is low throughout the break state
  p_break_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_state |-> !txd);

  // R4: the line can change only after a bit boundary
  p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(txd));

  // R5: the holding register empties only at a boundary outside break
  p_take_on_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_full) |-> ($past(tick) && !$past(brk_state)));

  // R10: an idle shifter leaves the line high
  p_idle_mark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk_state) |-> txd);
endmodule

bind async_tx async_tx_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .cts_n    (cts_n),
  .hre      (hre),
  .txd      (txd),
  .tick     (tick),
  .hold_full(hold_full),
  .brk_state(brk_state),
  .busy     (busy)
);

// File: tb/test_async_tx.sv
`timescale 1ns/1ps
module test_async_tx;
  logic       clk, rst_n, wr_en, word8, two_stop, brk, cts_n;
  logic [7:0] wr_data;
  logic [1:0] par_sel, div_sel;
  logic       txd, hre;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  async_tx i_async_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .word8(word8), .par_sel(par_sel), .two_stop(two_stop),
    .div_sel(div_sel), .brk(brk), .cts_n(cts_n), .txd(txd), .hre(hre)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #3;
  endtask

  function automatic int div_n(input logic [1:0] d);
    if (d == 2'b00) return 1;
    if (d == 2'b01) return 16;
    return 64;
  endfunction

  task automatic build(input logic [7:0] d, output logic [11:0] fr, output int len);
    int ones;
    int nb;
    fr = '1;
    len = 0;
    ones = 0;
    nb = word8 ? 8 : 7;
    fr[len] = 1'b0; len++;
    for (int i = 0; i < nb; i++) begin
      fr[len] = d[i]; len++;
      ones += d[i];
    end
    if (par_sel == 2'b01) begin fr[len] = 1'((ones % 2)); len++; end
    if (par_sel == 2'b10) begin fr[len] = 1'(((ones + 1) % 2)); len++; end
    fr[len] = 1'b1; len++;
    if (two_stop) begin fr[len] = 1'b1; len++; end
  endtask

  task automatic wait_start(input int limit, output int waited);
    waited = 0;
    while (txd !== 1'b0 && waited < limit) begin
      step();
      waited++;
    end
  endtask

  // Current sample must be the first cycle of the start bit.
  task automatic check_frame(input logic [7:0] d, input string req,
                             input bit do_wr, input logic [7:0] wbyte);
    logic [11:0] fr;
    int len, n, bad_at, act, exp;
    build(d, fr, len);
    n = div_n(div_sel);
    bad_at = -1; act = 0; exp = 0;
    for (int i = 0; i < len; i++) begin
      for (int j = 0; j < n; j++) begin
        if (txd !== fr[i] && bad_at < 0) begin
          bad_at = i * n + j; act = int'(txd); exp = int'(fr[i]);
        end
        if (do_wr && i == 2 && j == 0) begin wr_en = 1'b1; wr_data = wbyte; end
        step();
        wr_en = 1'b0;
      end
    end
    chk(bad_at < 0, req, $sformatf("frame of 0x%02h bad at cycle %0d", d, bad_at), act, exp);
  endtask

  task automatic send_one(input logic [7:0] d, input string req);
    int w;
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
    chk(hre === 1'b0, "R6", "hre after write", int'(hre), 0);
    wait_start(div_n(div_sel) + 4, w);
    chk(w <= div_n(div_sel), "R10", "start latency", w, div_n(div_sel));
    check_frame(d, req, 1'b0, 8'h00);
    chk(hre === 1'b1, "R6", "hre after transfer", int'(hre), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [8];
    int w, highs;
    bit ok;
    vals = '{8'h00, 8'hFF, 8'h80, 8'h55, 8'h01, 8'hA6, 8'h7E, 8'h3B};
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; word8 = 1'b1; par_sel = 2'b00;
    two_stop = 1'b0; div_sel = 2'b00; brk = 1'b0; cts_n = 1'b0;
    repeat (3) step();
    chk(txd === 1'b1, "R1", "txd in reset", int'(txd), 1);
    chk(hre === 1'b1, "R1", "hre in reset", int'(hre), 1);
    rst_n = 1'b1;
    repeat (5) step();
    chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
    chk(hre === 1'b1, "R1", "hre after reset", int'(hre), 1);

    // R2 R3: every format at one cycle per bit
    for (int wd = 0; wd < 2; wd++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 8; k++) begin
            word8 = 1'(wd); par_sel = 2'(p); two_stop = 1'(s);
            send_one(vals[k], (p == 1 || p == 2) ? "R3" : "R2");
          end

    // R4: sixteen cycles per bit, all formats
    div_sel = 2'b01;
    for (int wd = 0; wd < 2; wd++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 2; s++) begin
          word8 = 1'(wd); par_sel = 2'(p); two_stop = 1'(s);
          send_one(8'hA5 ^ 8'(p * 17 + s), "R4");
        end

    // R4: sixty-four cycles per bit, both encodings
    div_sel = 2'b10; word8 = 1'b1; par_sel = 2'b01; two_stop = 1'b1;
    send_one(8'h3C, "R4");
    div_sel = 2'b11; word8 = 1'b0; par_sel = 2'b10; two_stop = 1'b0;
    send_one(8'h81, "R4");

    // R5: second byte written mid-character follows with no gap
    div_sel = 2'b01; word8 = 1'b1; par_sel = 2'b00; two_stop = 1'b0;
    wr_en = 1'b1; wr_data = 8'hC3;
    step();
    wr_en = 1'b0;
    wait_start(20, w);
    chk(hre === 1'b1, "R6", "hre once first byte taken", int'(hre), 1);
    check_frame(8'hC3, "R5", 1'b1, 8'h5A);
    chk(txd === 1'b0, "R5", "no gap before second start", int'(txd), 0);
    check_frame(8'h5A, "R5", 1'b0, 8'h00);

    // R7: clear-to-send masks the flag only
    div_sel = 2'b00;
    cts_n = 1'b1;
    #0.5;
    chk(hre === 1'b0, "R7", "hre with cts_n high", int'(hre), 0);
    wr_en = 1'b1; wr_data = 8'h96;
    step();
    wr_en = 1'b0;
    wait_start(4, w);
    check_frame(8'h96, "R7", 1'b0, 8'h00);
    chk(hre === 1'b0, "R7", "hre still masked", int'(hre), 0);
    cts_n = 1'b0;
    #0.5;
    chk(hre === 1'b1, "R7", "hre after cts_n low", int'(hre), 1);

    // R8 R9: break at sixteen cycles per bit
    div_sel = 2'b01;
    wr_en = 1'b1; wr_data = 8'hFF;
    step();
    wr_en = 1'b0;
    wait_start(20, w);
    repeat (24) step();
    brk = 1'b1;
    repeat (18) step();
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (txd !== 1'b0) ok = 1'b0;
      step();
    end
    chk(ok, "R8", "line low during break", int'(ok), 1);
    wr_en = 1'b1; wr_data = 8'h4D;
    step();
    wr_en = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (txd !== 1'b0 || hre !== 1'b0) ok = 1'b0;
      step();
    end
    chk(ok, "R8", "byte held, line low", int'(ok), 1);
    brk = 1'b0;
    w = 0;
    while (txd !== 1'b1 && w < 40) begin step(); w++; end
    highs = 0;
    while (txd === 1'b1 && highs < 200) begin step(); highs++; end
    chk(highs >= 16, "R9", "mark length after break", highs, 16);
    check_frame(8'h4D, "R8", 1'b0, 8'h00);

    step();
    chk(txd === 1'b1, "R10", "idle line", int'(txd), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule